// File: doc/BRIEF.md
# External Data-Memory Bus Cycle Sequencer with Programmable Stretch

This block runs one read or write cycle on a multiplexed external data bus. A cycle opens with an address-latch pulse. It then waits through an address setup time, drives the active-low read or write strobe, and finishes with a hold phase before it raises a one-cycle done pulse. A 3-bit stretch code slows the cycle down for slow memories and peripherals. The code maps non-linearly to a number of stretch cycles, and those extra clocks are shared out differently between setup, strobe and hold depending on the code range.

The host raises `req_i` for one clock. With it, the host presents the direction, address, write data, the stretch code and a page-hit flag, which comes from page comparison logic outside this block. On a page hit the address-latch phase is skipped, so the cycle is shorter. Read data is captured from `rdata_i` on the clock edge at which the read strobe is released.

All phase lengths are counted in system clocks. A stretch cycle lasts `STRETCH_CLKS` system clocks. With the default parameters, the fastest cycle on a page miss takes two basic cycles of four clocks each.

Top module: `memx_stretch_seq`

## Requirements
- R1: After reset and while idle: `rd_n_o` and `wr_n_o` are 1, and `ale_o`, `ad_oe_o` and `done_o` are 0.
- R2: `done_o` is high for exactly one clock, in the first clock after the hold phase. With code 0 on a page miss, the cycle lasts 8 clocks from acceptance: ALE 2, setup 2, strobe 2, hold 2.
- R3: `rd_n_o` and `wr_n_o` are never low together. A read (write_i=0) pulses only `rd_n_o`, and a write (write_i=1) pulses only `wr_n_o`.
- R4: Codes 0..7 give stretch counts 0,1,2,3,7,8,9,10. The strobe lasts STRETCH_CLKS/2 clocks for code 0, count×STRETCH_CLKS for codes 1..3, and (count−3)×STRETCH_CLKS for codes 4..7. With the defaults this is 2,4,8,12,16,20,24,28 clocks.
- R5: Setup and hold each last 2 clocks for code 0. Codes 1..3 add one clock to each. Codes 4..7 add 2×STRETCH_CLKS to setup and STRETCH_CLKS to hold.
- R6: On a page miss, `ale_o` is high for ALE_CLKS clocks, plus STRETCH_CLKS for codes 4..7. On a page hit there is no ALE pulse, and setup follows acceptance directly.
- R7: For a write, `ad_oe_o` is high from the first setup clock through the last hold clock. For a read it stays low.
- R8: `rdata_o` takes the value `rdata_i` had in the last strobe clock of a read, and it keeps that value afterwards.
- R9: Direction, address, write data, code and page-hit flag are sampled only on acceptance. `addr_o` and `wdata_o` show the captured values. A request while a cycle is in progress is ignored.
- R10: A request present in the clock where `done_o` is high is accepted, and the next cycle starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a bus cycle (accepted when idle) |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| page_hit_i | input | 1 | Address lies in the page already latched |
| stretch_i | input | 3 | Stretch code 0..7 |
| rdata_i | input | DW | Data returned by the memory |
| ale_o | output | 1 | Address-latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ad_oe_o | output | 1 | Drive write data onto the bus |
| addr_o | output | AW | Captured address |
| wdata_o | output | DW | Captured write data |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
Two events can land in the same clock. The done pulse of one cycle can coincide with acceptance of the next request. The release of the read strobe coincides with the capture of read data. The bench starts back-to-back cycles by holding a request in the done clock, and it expects the first phase of the new cycle in the very next clock. It drives `rdata_i` with the wanted value only in the last strobe clock, and with its complement in every other clock, so that capture one clock early or late is caught. A reference model checks every clock against a sequence rebuilt from the requirement tables. A stray request with altered code, page flag and direction is injected mid-cycle and must leave that sequence unchanged.

// File: rtl/memx_pkg.sv
package memx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  // Non-linear code to stretch-count map.
  function automatic int stretch_count(input logic [2:0] code);
    case (code)
      3'd0: stretch_count = 0;
      3'd1: stretch_count = 1;
      3'd2: stretch_count = 2;
      3'd3: stretch_count = 3;
      3'd4: stretch_count = 7;
      3'd5: stretch_count = 8;
      3'd6: stretch_count = 9;
      default: stretch_count = 10;
    endcase
  endfunction

  function automatic int ale_len(input logic [2:0] code, input int sc, input int base);
    ale_len = base + (code[2] ? sc : 0);
  endfunction

  function automatic int setup_len(input logic [2:0] code, input int sc, input int base);
    if (code == 3'd0)  setup_len = base;
    else if (!code[2]) setup_len = base + 1;
    else               setup_len = base + 2 * sc;
  endfunction

  function automatic int strobe_len(input logic [2:0] code, input int sc);
    if (code == 3'd0)  strobe_len = sc / 2;
    else if (!code[2]) strobe_len = stretch_count(code) * sc;
    else               strobe_len = (stretch_count(code) - 3) * sc;
  endfunction

  function automatic int hold_len(input logic [2:0] code, input int sc, input int base);
    if (code == 3'd0)  hold_len = base;
    else if (!code[2]) hold_len = base + 1;
    else               hold_len = base + sc;
  endfunction

endpackage

// File: rtl/memx_req_latch.sv
module memx_req_latch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          page_hit_i,
  input  logic [2:0]    stretch_i,
  output logic          write_q,
  output logic          hit_q,
  output logic [2:0]    code_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      hit_q   <= 1'b0;
      code_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= write_i;
      hit_q   <= page_hit_i;
      code_q  <= stretch_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

endmodule

// File: rtl/memx_phase_ctrl.sv
module memx_phase_ctrl
  import memx_pkg::*;
#(
  parameter int STRETCH_CLKS = 4,
  parameter int ALE_CLKS     = 2,
  parameter int SETUP_CLKS   = 2,
  parameter int HOLD_CLKS    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       hit_in,
  input  logic [2:0] code_in,
  input  logic [2:0] code_q,
  output phase_e     phase,
  output logic       phase_end,
  output logic       done
);

  localparam int MAXLEN = ALE_CLKS + SETUP_CLKS + HOLD_CLKS + 10 * STRETCH_CLKS;
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt;
  phase_e        nxt;
  int            nxt_len;
  int            first_len;

  assign phase_end = (phase != PH_IDLE) && (cnt == '0);

  always_comb begin
    case (phase)
      PH_ALE:    nxt = PH_SETUP;
      PH_SETUP:  nxt = PH_STROBE;
      PH_STROBE: nxt = PH_HOLD;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      PH_SETUP:  nxt_len = setup_len(code_q, STRETCH_CLKS, SETUP_CLKS);
      PH_STROBE: nxt_len = strobe_len(code_q, STRETCH_CLKS);
      PH_HOLD:   nxt_len = hold_len(code_q, STRETCH_CLKS, HOLD_CLKS);
      default:   nxt_len = 1;
    endcase
    first_len = hit_in ? setup_len(code_in, STRETCH_CLKS, SETUP_CLKS)
                       : ale_len(code_in, STRETCH_CLKS, ALE_CLKS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (phase == PH_HOLD) && phase_end;
      if (accept) begin
        phase <= hit_in ? PH_SETUP : PH_ALE;
        cnt   <= CW'(first_len - 1);
      end else if (phase_end) begin
        phase <= nxt;
        cnt   <= CW'(nxt_len - 1);
      end else if (phase != PH_IDLE) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/memx_bus_drive.sv
module memx_bus_drive
  import memx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic          phase_end,
  input  logic          write_q,
  input  logic [DW-1:0] rdata_i,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          ad_oe_o,
  output logic          rd_capture,
  output logic [DW-1:0] rdata_o
);

  logic strobe_on;

  assign strobe_on  = (phase == PH_STROBE);
  assign ale_o      = (phase == PH_ALE);
  assign rd_n_o     = !(strobe_on && !write_q);
  assign wr_n_o     = !(strobe_on && write_q);
  assign ad_oe_o    = write_q && (phase == PH_SETUP || strobe_on || phase == PH_HOLD);
  assign rd_capture = strobe_on && phase_end && !write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_o <= '0;
    else if (rd_capture) rdata_o <= rdata_i;
  end

endmodule

// File: rtl/memx_stretch_seq.sv
module memx_stretch_seq
  import memx_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int STRETCH_CLKS = 4,
  parameter int ALE_CLKS     = 2,
  parameter int SETUP_CLKS   = 2,
  parameter int HOLD_CLKS    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          page_hit_i,
  input  logic [2:0]    stretch_i,
  input  logic [DW-1:0] rdata_i,
  output logic          ale_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          ad_oe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  phase_e     phase;
  logic       phase_end;
  logic       accept_w;
  logic       rd_capture_w;
  logic       write_q;
  logic       hit_q;
  logic [2:0] code_q;
  logic       unused_hit;

  assign accept_w   = req_i && (phase == PH_IDLE);
  assign unused_hit = hit_q;

  memx_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .accept(accept_w),
    .write_i(write_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .page_hit_i(page_hit_i), .stretch_i(stretch_i),
    .write_q(write_q), .hit_q(hit_q), .code_q(code_q),
    .addr_q(addr_o), .wdata_q(wdata_o)
  );

  memx_phase_ctrl #(
    .STRETCH_CLKS(STRETCH_CLKS), .ALE_CLKS(ALE_CLKS),
    .SETUP_CLKS(SETUP_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept_w),
    .hit_in(page_hit_i), .code_in(stretch_i), .code_q(code_q),
    .phase(phase), .phase_end(phase_end), .done(done_o)
  );

  memx_bus_drive #(.DW(DW)) u_drive (
    .clk(clk), .rst_n(rst_n), .phase(phase), .phase_end(phase_end),
    .write_q(write_q), .rdata_i(rdata_i),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ad_oe_o(ad_oe_o),
    .rd_capture(rd_capture_w), .rdata_o(rdata_o)
  );

endmodule

// File: rtl/memx_stretch_chk.sv
module memx_stretch_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept_w,
  input logic          rd_capture_w,
  input logic          ale_o,
  input logic          rd_n_o,
  input logic          wr_n_o,
  input logic          ad_oe_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_i,
  input logic [DW-1:0] rdata_o
);

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  a_r6_ale_apart_from_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (rd_n_o && wr_n_o));

  a_r7_oe_never_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> rd_n_o);

  a_r8_read_taken_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture_w |=> (rd_n_o && rdata_o == $past(rdata_i)));

  a_r2_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_accept_only_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> (rd_n_o && wr_n_o && !ale_o && !ad_oe_o));

endmodule

bind memx_stretch_seq memx_stretch_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_w(accept_w), .rd_capture_w(rd_capture_w),
  .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ad_oe_o(ad_oe_o),
  .done_o(done_o), .rdata_i(rdata_i), .rdata_o(rdata_o)
);

// File: tb/sim_memx_stretch_seq.sv
module sim_memx_stretch_seq;

  localparam int PERIOD = 10;
  localparam int SC     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        write_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        page_hit_i = 1'b0;
  logic [2:0]  stretch_i = '0;
  logic [7:0]  rdata_i = '0;
  logic        ale_o, rd_n_o, wr_n_o, ad_oe_o, done_o;
  logic [15:0] addr_o;
  logic [7:0]  wdata_o, rdata_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  memx_stretch_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .write_i(write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .page_hit_i(page_hit_i),
    .stretch_i(stretch_i), .rdata_i(rdata_i),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ad_oe_o(ad_oe_o),
    .addr_o(addr_o), .wdata_o(wdata_o), .rdata_o(rdata_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // expected bits per clock: {done, ale, rd_n, wr_n, oe}
  task automatic compare_row(input logic [4:0] e);
    chk(done_o == e[4],  "R2 done",     int'(done_o),  int'(e[4]));
    chk(ale_o  == e[3],  "R6 ale",      int'(ale_o),   int'(e[3]));
    chk(rd_n_o == e[2],  "R3/R4 rd_n",  int'(rd_n_o),  int'(e[2]));
    chk(wr_n_o == e[1],  "R3/R4 wr_n",  int'(wr_n_o),  int'(e[1]));
    chk(ad_oe_o == e[0], "R7 ad_oe",    int'(ad_oe_o), int'(e[0]));
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_i = 1'b0;
      compare_row(5'b0_0110);   // R1 quiet bus
    end
  endtask

  // Caller stands at a negedge with the block idle (or in its done clock).
  task automatic run_access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                            input bit hit, input logic [2:0] code, input logic [7:0] rv,
                            input bit stray);
    int ncnt[8] = '{0, 1, 2, 3, 7, 8, 9, 10};
    int al, su, st, ho, last_st;
    logic [4:0] rows[$];
    al = hit ? 0 : (2 + (code >= 4 ? SC : 0));
    su = 2 + ((code == 0) ? 0 : (code < 4 ? 1 : 2 * SC));
    ho = 2 + ((code == 0) ? 0 : (code < 4 ? 1 : SC));
    if (code == 0)     st = 2;
    else if (code < 4) st = ncnt[code] * SC;
    else               st = (ncnt[code] - 3) * SC;
    for (int i = 0; i < al; i++) rows.push_back(5'b0_1110);
    for (int i = 0; i < su; i++) rows.push_back({4'b0011, wr});
    for (int i = 0; i < st; i++) rows.push_back({2'b00, wr, !wr, wr});
    last_st = al + su + st - 1;
    for (int i = 0; i < ho; i++) rows.push_back({4'b0011, wr});
    rows.push_back(5'b1_0110);

    req_i = 1'b1; write_i = wr; addr_i = a; wdata_i = d;
    page_hit_i = hit; stretch_i = code;
    @(posedge clk);
    for (int k = 0; k < rows.size(); k++) begin
      @(negedge clk);
      if (stray && k == 1) begin
        // R9 stray request while busy, with every parameter altered
        req_i = 1'b1; write_i = !wr; page_hit_i = !hit;
        stretch_i = code ^ 3'b101; addr_i = ~a; wdata_i = ~d;
      end else begin
        req_i = 1'b0;
      end
      rdata_i = (k == last_st) ? rv : ~rv;
      compare_row(rows[k]);
      if (k == rows.size() - 1) begin
        chk(addr_o == a, "R9 addr_o", int'(addr_o), int'(a));
        if (wr) chk(wdata_o == d, "R9 wdata_o", int'(wdata_o), int'(d));
        else    chk(rdata_o == rv, "R8 rdata_o", int'(rdata_o), int'(rv));
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 2 + 1);
    // R1 reset state
    chk(rd_n_o == 1'b1 && wr_n_o == 1'b1, "R1 strobes in reset", int'({rd_n_o, wr_n_o}), 3);
    chk(ale_o == 1'b0 && ad_oe_o == 1'b0 && done_o == 1'b0, "R1 ale/oe/done in reset",
        int'({ale_o, ad_oe_o, done_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(3);

    // R2 basic miss read, code 0
    run_access(1'b0, 16'h1234, 8'h00, 1'b0, 3'd0, 8'hA5, 1'b0);
    idle_cycles(2);
    // R4 R5 R6 every code, miss and hit, read and write
    for (int c = 0; c < 8; c++) begin
      run_access(1'b1, 16'h2000 + 16'(c), 8'h30 + 8'(c), 1'b0, 3'(c), 8'h00, 1'b0);
      idle_cycles(1);
      run_access(1'b0, 16'h4100 + 16'(c), 8'h00, 1'b1, 3'(c), 8'h5A ^ 8'(c), 1'b0);
      idle_cycles(1);
    end
    // R9 stray requests while busy
    run_access(1'b0, 16'hBEEF, 8'h00, 1'b0, 3'd5, 8'h3C, 1'b1);
    idle_cycles(1);
    run_access(1'b1, 16'h0F0F, 8'hC3, 1'b1, 3'd1, 8'h00, 1'b1);
    idle_cycles(1);
    // R10 back-to-back: next request presented in the done clock
    run_access(1'b1, 16'h7777, 8'h11, 1'b0, 3'd2, 8'h00, 1'b0);
    run_access(1'b0, 16'h8888, 8'h00, 1'b1, 3'd4, 8'h96, 1'b0);
    run_access(1'b1, 16'h9999, 8'h22, 1'b0, 3'd7, 8'h00, 1'b0);
    idle_cycles(3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule